// File: doc/BRIEF.md
# Vectored Interrupt Status Controller

This block is the interrupt front end of a small 8-bit processor core. One eight-bit status/control register is read combinationally and written through a simple write strobe. It holds three latched flags for the core's own sources: a first pin edge event, a timer overflow event and a second pin edge event. It also holds four enables. The edge detectors and the timer sit outside the block and hand it one-cycle event strobes. A bank of peripheral request/enable pairs is folded into one read-only summary bit.

Each cycle the block looks at the registered flags and enables. When a global disable input is low and some enabled source is pending, it issues a one-cycle vector request together with a fixed address, and it clears the winning core flag. There is a hazard case: software clears an enable in the same cycle that the matching source fires, while interrupts are globally enabled. In that case the block requests the reset vector instead. Requests carry no handshake. The core must accept the pulse in the cycle it appears, so there is no back-pressure.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every bit of the status register reads 0 and no vector request is active.
- R2: Register layout: bit 4 is the first-pin flag, bit 5 the timer flag and bit 6 the second-pin flag. Bit 0 is the first-pin enable, bit 1 the timer enable, bit 2 the second-pin enable and bit 3 the peripheral enable. A write loads bits 6..0, and the new value reads back from the next cycle.
- R3: Bit 7 is read-only and equals the OR, over all peripherals, of each peripheral flag ANDed with its own enable. Writes to bit 7 have no effect.
- R4: The peripheral enable (bit 3) gates only the vector for the summary. A peripheral whose own enable is 0 never raises the summary.
- R5: An event strobe sets its flag on the next cycle, even when the flag's enable is 0 or the global disable is 1.
- R6: A vector request is a one-cycle pulse issued in the cycle after a pending, enabled source is seen. The addresses are 0x08 for the first pin, 0x10 for the timer, 0x18 for the second pin and 0x20 for the summary. The address reads 0 when no request is active.
- R7: When several enabled sources are pending, the lowest address wins. The order is first pin, then timer, then second pin, then summary.
- R8: Taking a core source's vector clears that flag. The summary is never cleared by vectoring.
- R9: While the global disable is 1, no vector request is issued.
- R10: When a software write and an event strobe hit the same flag in the same cycle, the flag ends up set. An event strobe also beats the clear caused by taking a vector.
- R11: The hazard case is a write that clears an enable that was 1, in the same cycle that the matching source fires, with the global disable at 0. For the summary, firing means the summary rises. In this case the next cycle carries a request to address 0x00, and the reset vector takes priority over all others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the status register |
| reg_wr_data | input | 8 | Write data; bit 7 ignored |
| reg_rd_data | output | 8 | Current register contents |
| evt_pin_a | input | 1 | First pin edge event strobe |
| evt_tmr_ovf | input | 1 | Timer overflow event strobe |
| evt_pin_b | input | 1 | Second pin edge event strobe |
| periph_flags | input | NUM_PERIPH | Peripheral request flags |
| periph_enables | input | NUM_PERIPH | Per-peripheral enables |
| glob_dis | input | 1 | Global interrupt disable |
| vec_req | output | 1 | One-cycle vector request |
| vec_addr | output | 8 | Vector address with the request |

## Verification
The bench aims at the collisions:
- An event landing in the same cycle as a write to its flag. A design that lets software win would lose the interrupt.
- An event landing as a vector clears the same flag. The same mistake would lose it there too.
- An enable cleared in the very cycle its source fires. A design without the hazard path would stay silent instead of sending the core to address 0x00.

It also stacks several pending sources to expose a wrong priority order. It holds the global disable high while flags pile up, so that an early request shows. It attempts writes to bit 7, which would corrupt the summary if they were accepted. It checks that the summary stays set after its vector is taken; a design that cleared it would drop later peripheral requests.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int VEC_W     = 8;
  localparam int NSRC      = 3;            // core sources with latched flags
  localparam int NPEND     = NSRC + 1;     // plus peripheral summary
  localparam int VEC_STEP  = 8;
  localparam logic [VEC_W-1:0] RESET_VEC = '0;

  // source index i vectors to (i+1)*VEC_STEP
  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'((idx + 1) * VEC_STEP);
  endfunction
endpackage

// File: rtl/irqv_summary.sv
module irqv_summary #(
  parameter int NUM_PERIPH = 8
) (
  input  logic [NUM_PERIPH-1:0] flags,
  input  logic [NUM_PERIPH-1:0] enables,
  output logic                  summary
);
  logic [NUM_PERIPH-1:0] qual;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_qual
    assign qual[g] = flags[g] & enables[g];
  end

  assign summary = |qual;
endmodule

// File: rtl/irqv_status_reg.sv
module irqv_status_reg
  import irqv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      wr_data,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] take,
  output logic [NSRC-1:0] flags_q,
  output logic [NPEND-1:0] en_q
);
  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags_q[g] <= 1'b0;
      else
        flags_q[g] <= evt[g] | (wr_en ? wr_data[4+g] : (flags_q[g] & ~take[g]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[NPEND-1:0];
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (flags_q == '0 && en_q == '0));

  assert_flag_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));

  assert_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wr_en) |-> ((flags_q & $past(take & ~evt)) == '0));
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_dis,
  input  logic [NSRC-1:0]  flags,
  input  logic [NPEND-1:0] en,
  input  logic             summary,
  input  logic             wr_en,
  input  logic [NPEND-1:0] wr_en_bits,
  input  logic [NSRC-1:0]  evt,
  output logic [NSRC-1:0]  take,
  output logic             vec_req,
  output logic [VEC_W-1:0] vec_addr
);
  logic             sum_q;
  logic [NPEND-1:0] pend, arm;
  logic             hazard, any;
  int               win;
  logic             req_n;
  logic [VEC_W-1:0] addr_n;

  assign pend   = {summary & en[NPEND-1], flags & en[NSRC-1:0]};
  assign arm    = {summary & ~sum_q, evt};
  assign hazard = ~glob_dis & wr_en & (|(arm & en & ~wr_en_bits));
  assign any    = |pend;
  assign req_n  = ~glob_dis & (hazard | any);

  always_comb begin
    win = 0;
    for (int i = NPEND - 1; i >= 0; i--)
      if (pend[i]) win = i;
  end

  always_comb begin
    take = '0;
    if (req_n && !hazard && win < NSRC) take[win] = 1'b1;
    if (!req_n)      addr_n = '0;
    else if (hazard) addr_n = RESET_VEC;
    else             addr_n = vec_of(win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q    <= 1'b0;
      vec_req  <= 1'b0;
      vec_addr <= '0;
    end else begin
      sum_q    <= summary;
      vec_req  <= req_n;
      vec_addr <= addr_n;
    end
  end

  assert_gd_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(!glob_dis));

  assert_hazard_vec_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hazard) |-> (vec_req && vec_addr == RESET_VEC));

  assert_one_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr_en,
  input  logic [7:0]            reg_wr_data,
  output logic [7:0]            reg_rd_data,
  input  logic                  evt_pin_a,
  input  logic                  evt_tmr_ovf,
  input  logic                  evt_pin_b,
  input  logic [NUM_PERIPH-1:0] periph_flags,
  input  logic [NUM_PERIPH-1:0] periph_enables,
  input  logic                  glob_dis,
  output logic                  vec_req,
  output logic [7:0]            vec_addr
);
  logic [NSRC-1:0]  evt, flags, take;
  logic [NPEND-1:0] en;
  logic             summary;

  assign evt = {evt_pin_b, evt_tmr_ovf, evt_pin_a};

  irqv_summary #(.NUM_PERIPH(NUM_PERIPH)) u_summary (
    .flags(periph_flags), .enables(periph_enables), .summary(summary));

  irqv_status_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .evt(evt), .take(take), .flags_q(flags), .en_q(en));

  irqv_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .glob_dis(glob_dis), .flags(flags), .en(en),
    .summary(summary), .wr_en(reg_wr_en), .wr_en_bits(reg_wr_data[NPEND-1:0]),
    .evt(evt), .take(take), .vec_req(vec_req), .vec_addr(vec_addr));

  assign reg_rd_data = {summary, flags, en};

  assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_addr == 8'h10) |-> $past(!(flags[0] && en[0])));

  assert_pin_a_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && vec_addr == 8'h08) |-> $past(flags[0] && en[0] && !glob_dis));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [7:0]    reg_wr_data = '0;
  logic [7:0]    reg_rd_data;
  logic          evt_pin_a = 1'b0, evt_tmr_ovf = 1'b0, evt_pin_b = 1'b0;
  logic [NP-1:0] periph_flags = '0, periph_enables = '0;
  logic          glob_dis = 1'b0;
  logic          vec_req;
  logic [7:0]    vec_addr;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [2:0] m_fl = '0;
  logic [3:0] m_en = '0;
  logic       m_sp = 1'b0;
  logic       m_vq = 1'b0;
  logic [7:0] m_va = '0;

  always #2 clk = ~clk;

  irq_vector_ctrl #(.NUM_PERIPH(NP)) u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .evt_pin_a(evt_pin_a), .evt_tmr_ovf(evt_tmr_ovf),
    .evt_pin_b(evt_pin_b), .periph_flags(periph_flags),
    .periph_enables(periph_enables), .glob_dis(glob_dis),
    .vec_req(vec_req), .vec_addr(vec_addr));

  function automatic logic [7:0] exp_rd(input logic [NP-1:0] pf, input logic [NP-1:0] pe,
                                        input logic [2:0] fl, input logic [3:0] en);
    return {|(pf & pe), fl, en};
  endfunction

  task automatic compare(input string tag);
    logic [7:0] er;
    er = exp_rd(periph_flags, periph_enables, m_fl, m_en);
    n_cmp++;
    if (reg_rd_data !== er) begin
      n_bad++;
      $display("FAIL %s reg_rd_data actual=%h expected=%h", tag, reg_rd_data, er);
    end
    n_cmp++;
    if (vec_req !== m_vq || vec_addr !== m_va) begin
      n_bad++;
      $display("FAIL %s vector actual=%b/%h expected=%b/%h", tag, vec_req, vec_addr, m_vq, m_va);
    end
  endtask

  task automatic tick(input string tag, input logic wr, input logic [7:0] wd,
                      input logic [2:0] ev, input logic [NP-1:0] pf,
                      input logic [NP-1:0] pe, input logic gd);
    logic       sum, hz, any, vq;
    logic [3:0] pend, arm;
    logic [2:0] take;
    logic [7:0] va;
    int         win;
    reg_wr_en = wr; reg_wr_data = wd;
    {evt_pin_b, evt_tmr_ovf, evt_pin_a} = ev;
    periph_flags = pf; periph_enables = pe; glob_dis = gd;
    sum  = |(pf & pe);
    pend = {sum & m_en[3], m_fl & m_en[2:0]};
    arm  = {sum & ~m_sp, ev};
    hz   = !gd && wr && (|(arm & m_en & ~wd[3:0]));
    any  = |pend;
    win  = 0;
    for (int i = 3; i >= 0; i--) if (pend[i]) win = i;
    vq   = !gd && (hz || any);
    va   = !vq ? 8'h00 : (hz ? 8'h00 : 8'((win + 1) * 8));
    take = '0;
    if (vq && !hz && win < 3) take[win] = 1'b1;
    @(posedge clk); #1;
    m_fl = ev | (wr ? wd[6:4] : (m_fl & ~take));
    if (wr) m_en = wd[3:0];
    m_sp = sum; m_vq = vq; m_va = va;
    compare(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++)
      tick(tag, 1'b0, 8'h00, 3'b000, periph_flags, periph_enables, glob_dis);
  endtask

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare("R1");
    idle("R1", 2);

    // R2 layout and readback, enables off so no vectors
    tick("R2", 1'b1, 8'h70, 3'b000, '0, '0, 1'b0);
    tick("R2", 1'b1, 8'h00, 3'b000, '0, '0, 1'b0);
    // R3 bit 7 read-only
    tick("R3", 1'b1, 8'h80, 3'b000, '0, '0, 1'b0);
    tick("R3", 1'b0, 8'h00, 3'b000, 8'h04, 8'h04, 1'b0);
    tick("R3", 1'b1, 8'h00, 3'b000, 8'h04, 8'h04, 1'b0);
    // R4 own enable and master enable
    tick("R4", 1'b0, 8'h00, 3'b000, 8'h01, 8'h00, 1'b0);
    tick("R4", 1'b0, 8'h00, 3'b000, 8'h01, 8'h01, 1'b0);
    tick("R4", 1'b1, 8'h08, 3'b000, 8'h01, 8'h01, 1'b0);
    idle("R8", 3);  // summary keeps requesting, never cleared
    tick("R4", 1'b1, 8'h00, 3'b000, 8'h00, 8'h00, 1'b0);
    // R5 flags set while disabled
    tick("R5", 1'b0, 8'h00, 3'b111, '0, '0, 1'b1);
    tick("R9", 1'b1, 8'h07, 3'b000, '0, '0, 1'b1);
    idle("R9", 2);
    // R7 priority drain once global enable returns
    tick("R7", 1'b0, 8'h00, 3'b000, '0, '0, 1'b0);
    idle("R7", 4);
    // R10 write clearing a flag while its event fires
    tick("R10", 1'b1, 8'h00, 3'b001, '0, '0, 1'b0);
    tick("R10", 1'b0, 8'h00, 3'b000, '0, '0, 1'b0);
    // R10 event beats vector clear
    tick("R10", 1'b1, 8'h01, 3'b000, '0, '0, 1'b0);
    tick("R10", 1'b0, 8'h00, 3'b001, '0, '0, 1'b0);
    idle("R8", 2);
    // R11 hazard: clear enable while source fires
    tick("R11", 1'b1, 8'h07, 3'b000, '0, '0, 1'b1);
    tick("R11", 1'b1, 8'h06, 3'b001, '0, '0, 1'b0);
    idle("R11", 3);
    tick("R11", 1'b1, 8'h08, 3'b000, '0, '0, 1'b1);
    tick("R11", 1'b1, 8'h00, 3'b000, 8'h10, 8'h10, 1'b0);
    idle("R11", 2);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic       wr;
      logic [2:0] ev;
      wr = ($urandom_range(0, 3) == 0);
      ev = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
      tick("R6", wr, 8'($urandom), ev, NP'($urandom & $urandom),
           NP'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule